// File: doc/BRIEF.md
# Index-Prefix Opcode Decode Tracker

This block watches the opcode bytes that an 8-bit processor fetches, one byte per strobe. It remembers whether an index prefix byte (0xDD for the first index register, 0xFD for the second) has just been seen. For the next real opcode, it tells the datapath which 16-bit pair to use: the normal HL pair, or one of the two index registers.

For that opcode it also reports two things. The first is whether a signed displacement byte has to be fetched, because the operand is memory addressed through the pair. The second is whether the plain H or L register select must be steered to the high or low half of the index register.

A prefix byte on its own produces a decode result marked as a prefix-only cycle. That result carries a fixed T-state count and nothing else. Every decode result is registered and appears one clock after the byte that caused it.

Top module: `idx_prefix_tracker`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `dec_valid` is 0 and `pair_sel` is 0. A prefix that was seen before a reset is forgotten, so a following 0x21 reports `pair_sel` = 0.
- R2: After a 0xDD byte, the next opcode that uses HL as a 16-bit pair reports `pair_sel` = 1 (IX). After a 0xFD byte it reports `pair_sel` = 2 (IY). Without a prefix it reports 0 (HL). The pair opcodes are 0x09, 0x19, 0x21, 0x22, 0x23, 0x29, 0x2A, 0x2B, 0x39, 0xE1, 0xE3, 0xE5, 0xE9 and 0xF9.
- R3: A 0xDD or 0xFD byte gives a result with `pfx_only` = 1, `pfx_tstates` = 4, `disp_need` = 0, `half_sub` = 0 and `pair_sel` = 0. Any other result has `pfx_only` = 0 and `pfx_tstates` = 0.
- R4: A prefixed opcode with a memory operand addressed through HL reports `disp_need` = 1, with `pair_sel` set to the index register. The same opcode without a prefix reports `disp_need` = 0. These opcodes are 0x34 to 0x36, 0x40 to 0x7F with a source or destination field of 6 (HALT 0x76 excluded), 0x80 to 0xBF with a source field of 6, and 0xCB.
- R5: A prefixed opcode that names H or L as a plain 8-bit operand reports `half_sub` = 1, `disp_need` = 0, and `pair_sel` set to the index register.
- R6: A prefixed opcode that uses neither HL, H nor L decodes as if it had no prefix: `pair_sel` = 0, `disp_need` = 0, `half_sub` = 0. This includes HALT (0x76).
- R7: In a run of prefix bytes, the last one alone selects the register.
- R8: The prefix state clears once the first non-prefix opcode has been decoded, so the opcode after it decodes unprefixed.
- R9: An opcode with both an indirect memory operand and an H or L operand (0x66, 0x6E, 0x74, 0x75) uses the index register only for the address: `disp_need` = 1 and `half_sub` = 0.
- R10: The register jump 0xE9 under a prefix reports the index register in `pair_sel`, with `disp_need` = 0.
- R11: A cycle with `op_valid` low gives `dec_valid` = 0 on the next cycle and leaves a pending prefix in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | The byte on op_byte is a fetched opcode byte |
| op_byte | input | 8 | Fetched opcode byte |
| dec_valid | output | 1 | A decode result is present this cycle |
| pair_sel | output | 2 | Effective pair: 0 HL, 1 IX, 2 IY |
| disp_need | output | 1 | A displacement byte must be fetched |
| half_sub | output | 1 | The H/L selects map to the index register halves |
| pfx_only | output | 1 | This result is for a prefix byte alone |
| pfx_tstates | output | 3 | T-states of a prefix-only cycle, otherwise 0 |

## Verification
The assertions check the cross-output rules on every cycle:
- a prefix-only result carries the fixed count and no substitution;
- a displacement or half-register request always comes with an index pair;
- the two requests never coincide;
- an idle input cycle produces no result.

Only the bench scenarios can show the sequence-dependent behaviour. This covers which prefix in a chain wins, the clearing after one opcode, a prefix held across idle cycles, a reset dropping a pending prefix, and the per-opcode classification, including the mixed memory-plus-H/L forms and the register jump.

// File: rtl/idx_prefix_pkg.sv
package idx_prefix_pkg;
  typedef enum logic [1:0] {
    PAIR_HL = 2'd0,
    PAIR_IX = 2'd1,
    PAIR_IY = 2'd2
  } pair_e;

  typedef struct packed {
    logic mem_ind;   // memory operand addressed through the pair
    logic half_reg;  // plain H or L operand (no memory operand)
    logic pair16;    // HL used as a 16-bit pair
  } opclass_t;
endpackage

// File: rtl/idx_opclass.sv
module idx_opclass
  import idx_prefix_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] op,
  output opclass_t        cls
);
  localparam int FLD_W = 3;

  logic [1:0]       grp;
  logic [FLD_W-1:0] dst;
  logic [FLD_W-1:0] src;
  logic             src_hl;
  logic             dst_hl;
  logic             mem_any;
  logic             half_any;

  assign grp = op[7:6];
  assign dst = op[5:3];
  assign src = op[2:0];
  assign src_hl = (src == 3'd4) || (src == 3'd5);
  assign dst_hl = (dst == 3'd4) || (dst == 3'd5);

  always_comb begin
    mem_any = 1'b0;
    if (op == 8'h34 || op == 8'h35 || op == 8'h36) mem_any = 1'b1;
    if (grp == 2'd1 && (dst == 3'd6 || src == 3'd6) && op != 8'h76) mem_any = 1'b1;
    if (grp == 2'd2 && src == 3'd6) mem_any = 1'b1;
    if (op == 8'hCB) mem_any = 1'b1;
  end

  always_comb begin
    half_any = 1'b0;
    if (grp == 2'd0 && dst_hl && (src == 3'd4 || src == 3'd5 || src == 3'd6)) half_any = 1'b1;
    if (grp == 2'd1 && (dst_hl || src_hl)) half_any = 1'b1;
    if (grp == 2'd2 && src_hl) half_any = 1'b1;
  end

  always_comb begin
    cls.mem_ind  = mem_any;
    cls.half_reg = half_any && !mem_any;
    unique case (op)
      8'h09, 8'h19, 8'h29, 8'h39,
      8'h21, 8'h22, 8'h2A, 8'h23, 8'h2B,
      8'hE1, 8'hE3, 8'hE5, 8'hE9, 8'hF9: cls.pair16 = 1'b1;
      default:                           cls.pair16 = 1'b0;
    endcase
  end
endmodule

// File: rtl/idx_prefix_state.sv
module idx_prefix_state
  import idx_prefix_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  take,
  input  logic  is_ix_pfx,
  input  logic  is_iy_pfx,
  output pair_e pfx_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pfx_q <= PAIR_HL;
    end else if (take) begin
      if (is_ix_pfx)      pfx_q <= PAIR_IX;
      else if (is_iy_pfx) pfx_q <= PAIR_IY;
      else                pfx_q <= PAIR_HL;
    end
  end
endmodule

// File: rtl/idx_prefix_tracker.sv
module idx_prefix_tracker
  import idx_prefix_pkg::*;
#(
  parameter int         OP_W    = 8,
  parameter int         TST_W   = 3,
  parameter int         PFX_T   = 4,
  parameter logic [7:0] IX_CODE = 8'hDD,
  parameter logic [7:0] IY_CODE = 8'hFD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op_byte,
  output logic             dec_valid,
  output logic [1:0]       pair_sel,
  output logic             disp_need,
  output logic             half_sub,
  output logic             pfx_only,
  output logic [TST_W-1:0] pfx_tstates
);
  localparam logic [TST_W-1:0] PFX_T_V = TST_W'(PFX_T);

  logic     is_ix;
  logic     is_iy;
  logic     is_pfx;
  logic     pfx_act;
  pair_e    pfx_q;
  opclass_t cls;
  pair_e    pair_n;

  assign is_ix  = (op_byte == IX_CODE);
  assign is_iy  = (op_byte == IY_CODE);
  assign is_pfx = is_ix || is_iy;

  idx_opclass #(.OP_W(OP_W)) u_cls (
    .op  (op_byte),
    .cls (cls)
  );

  idx_prefix_state u_state (
    .clk       (clk),
    .rst       (rst),
    .take      (op_valid),
    .is_ix_pfx (is_ix),
    .is_iy_pfx (is_iy),
    .pfx_q     (pfx_q)
  );

  assign pfx_act = (pfx_q != PAIR_HL);

  always_comb begin
    pair_n = PAIR_HL;
    if (pfx_act && (cls.mem_ind || cls.half_reg || cls.pair16)) pair_n = pfx_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !op_valid) begin
      dec_valid   <= 1'b0;
      pair_sel    <= PAIR_HL;
      disp_need   <= 1'b0;
      half_sub    <= 1'b0;
      pfx_only    <= 1'b0;
      pfx_tstates <= '0;
    end else if (is_pfx) begin
      dec_valid   <= 1'b1;
      pair_sel    <= PAIR_HL;
      disp_need   <= 1'b0;
      half_sub    <= 1'b0;
      pfx_only    <= 1'b1;
      pfx_tstates <= PFX_T_V;
    end else begin
      dec_valid   <= 1'b1;
      pair_sel    <= pair_n;
      disp_need   <= pfx_act && cls.mem_ind;
      half_sub    <= pfx_act && cls.half_reg;
      pfx_only    <= 1'b0;
      pfx_tstates <= '0;
    end
  end
endmodule

// File: rtl/idx_prefix_tracker_chk.sv
module idx_prefix_tracker_chk #(
  parameter int         OP_W    = 8,
  parameter int         TST_W   = 3,
  parameter int         PFX_T   = 4,
  parameter logic [7:0] IX_CODE = 8'hDD,
  parameter logic [7:0] IY_CODE = 8'hFD
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [OP_W-1:0]  op_byte,
  input logic             dec_valid,
  input logic [1:0]       pair_sel,
  input logic             disp_need,
  input logic             half_sub,
  input logic             pfx_only,
  input logic [TST_W-1:0] pfx_tstates
);
  AST_PFX_SHAPE: assert property (@(posedge clk) disable iff (rst)
    pfx_only |-> (dec_valid && pfx_tstates == TST_W'(PFX_T) && !disp_need && !half_sub && pair_sel == 2'd0)); // R3
  AST_PFX_FROM_BYTE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_byte == IX_CODE || op_byte == IY_CODE)) |=> pfx_only); // R3
  AST_DISP_IDX: assert property (@(posedge clk) disable iff (rst)
    disp_need |-> (pair_sel == 2'd1 || pair_sel == 2'd2)); // R4
  AST_HALF_IDX: assert property (@(posedge clk) disable iff (rst)
    half_sub |-> (pair_sel != 2'd0 && !disp_need)); // R5
  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !dec_valid); // R11
  AST_NO_PAIR3: assert property (@(posedge clk) disable iff (rst)
    pair_sel != 2'd3); // R2
endmodule

bind idx_prefix_tracker idx_prefix_tracker_chk #(
  .OP_W(OP_W), .TST_W(TST_W), .PFX_T(PFX_T), .IX_CODE(IX_CODE), .IY_CODE(IY_CODE)
) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_byte(op_byte),
  .dec_valid(dec_valid), .pair_sel(pair_sel), .disp_need(disp_need),
  .half_sub(half_sub), .pfx_only(pfx_only), .pfx_tstates(pfx_tstates)
);

// File: tb/idx_prefix_tracker_tb.sv
module idx_prefix_tracker_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [7:0] op_byte = 8'h00;
  logic       dec_valid;
  logic [1:0] pair_sel;
  logic       disp_need;
  logic       half_sub;
  logic       pfx_only;
  logic [2:0] pfx_tstates;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  idx_prefix_tracker u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_byte(op_byte),
    .dec_valid(dec_valid), .pair_sel(pair_sel), .disp_need(disp_need),
    .half_sub(half_sub), .pfx_only(pfx_only), .pfx_tstates(pfx_tstates)
  );

  // {req[3:0], valid, byte[7:0], pair[1:0], disp, half, pfx}
  localparam int NV = 32;
  localparam logic [17:0] VEC [NV] = '{
    {4'd8,  1'b1, 8'h21, 2'd0, 1'b0, 1'b0, 1'b0},
    {4'd3,  1'b1, 8'hDD, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'd2,  1'b1, 8'h21, 2'd1, 1'b0, 1'b0, 1'b0},
    {4'd8,  1'b1, 8'h21, 2'd0, 1'b0, 1'b0, 1'b0},
    {4'd3,  1'b1, 8'hFD, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'd2,  1'b1, 8'h2A, 2'd2, 1'b0, 1'b0, 1'b0},
    {4'd3,  1'b1, 8'hDD, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'd4,  1'b1, 8'h7E, 2'd1, 1'b1, 1'b0, 1'b0},
    {4'd4,  1'b1, 8'h7E, 2'd0, 1'b0, 1'b0, 1'b0},
    {4'd3,  1'b1, 8'hFD, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'd5,  1'b1, 8'h44, 2'd2, 1'b0, 1'b1, 1'b0},
    {4'd3,  1'b1, 8'hDD, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'd6,  1'b1, 8'h47, 2'd0, 1'b0, 1'b0, 1'b0},
    {4'd3,  1'b1, 8'hFD, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'd6,  1'b1, 8'h76, 2'd0, 1'b0, 1'b0, 1'b0},
    {4'd7,  1'b1, 8'hDD, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'd7,  1'b1, 8'hFD, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'd7,  1'b1, 8'hDD, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'd7,  1'b1, 8'hFD, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'd7,  1'b1, 8'h29, 2'd2, 1'b0, 1'b0, 1'b0},
    {4'd3,  1'b1, 8'hDD, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'd9,  1'b1, 8'h66, 2'd1, 1'b1, 1'b0, 1'b0},
    {4'd3,  1'b1, 8'hFD, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'd10, 1'b1, 8'hE9, 2'd2, 1'b0, 1'b0, 1'b0},
    {4'd3,  1'b1, 8'hDD, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'd11, 1'b0, 8'h35, 2'd0, 1'b0, 1'b0, 1'b0},
    {4'd11, 1'b1, 8'h35, 2'd1, 1'b1, 1'b0, 1'b0},
    {4'd3,  1'b1, 8'hFD, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'd4,  1'b1, 8'hCB, 2'd2, 1'b1, 1'b0, 1'b0},
    {4'd3,  1'b1, 8'hDD, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'd5,  1'b1, 8'h2C, 2'd1, 1'b0, 1'b1, 1'b0},
    {4'd4,  1'b1, 8'h86, 2'd0, 1'b0, 1'b0, 1'b0}
  };
  // Tags covered by the table: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_result(input string req, input logic v, input logic [1:0] p,
                              input logic d, input logic h, input logic f);
    check(req, "dec_valid", int'(dec_valid), int'(v));
    if (v) begin
      check(req, "pair_sel", int'(pair_sel), int'(p));
      check(req, "disp_need", int'(disp_need), int'(d));
      check(req, "half_sub", int'(half_sub), int'(h));
      check(req, "pfx_only", int'(pfx_only), int'(f));
      check(req, "pfx_tstates", int'(pfx_tstates), f ? 4 : 0);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: outputs cleared while in reset
    check("R1", "dec_valid in reset", int'(dec_valid), 0);
    check("R1", "pair_sel in reset", int'(pair_sel), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "dec_valid after reset", int'(dec_valid), 0);

    for (int i = 0; i < NV; i++) begin
      op_valid = VEC[i][13];
      op_byte  = VEC[i][12:5];
      @(negedge clk);
      check_result($sformatf("R%0d", VEC[i][17:14]), VEC[i][13], VEC[i][4:3],
                   VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R1: a reset drops a pending prefix
    op_valid = 1'b1; op_byte = 8'hDD;
    @(negedge clk);
    check_result("R1", 1'b1, 2'd0, 1'b0, 1'b0, 1'b1);
    op_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R1", "dec_valid in reset", int'(dec_valid), 0);
    rst = 1'b0; op_valid = 1'b1; op_byte = 8'h21;
    @(negedge clk);
    check_result("R1", 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);

    // R11: a prefix held across several idle cycles
    op_byte = 8'hFD;
    @(negedge clk);
    op_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R11", "dec_valid idle", int'(dec_valid), 0);
    end
    op_valid = 1'b1; op_byte = 8'h74;  // R9: LD (HL),H form
    @(negedge clk);
    check_result("R9", 1'b1, 2'd2, 1'b1, 1'b0, 1'b0);
    op_valid = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule